// File: doc/BRIEF.md
# Single-Channel Dual-Address DMA Engine

This block is one DMA channel. It copies a programmed number of data units from a source address to a destination address. Each unit takes two bus cycles on a simple memory-style bus: a read at the source address, then a write of that same data at the destination address. The channel asks for the bus with `busReq` and drives the bus only after `busGnt` has answered. After each unit both addresses step forward by the unit size.

Software sets up the channel through a small write port. Register 0 holds the mode: request source, unit size, ownership mode and the software request bit. Register 1 holds the source address and register 2 the destination address. Register 3 holds the unit count, and writing it arms the channel.

A transfer can be started in two ways. One is a rising edge on `dreq`, answered by one-cycle pulses on `dreqClr` and `tcOut`. The other is an internal software request. The ownership mode decides whether the bus is given back after every unit (cycle stealing) or held until the count runs out (burst). An error reported by the bus stops the channel, sets a sticky flag and returns the channel to idle.

Top module: `dma_channel`

## Requirements
- R1: Each unit is one cycle with `memRd` high and `memAddr` equal to the source address. It is followed in the very next cycle by one cycle with `memWr` high, `memAddr` equal to the destination address, and `memWdata` equal to the `memRdata` value sampled during the read.
- R2: Mode bit 5 selects ownership. With 1 (burst), `busReq` stays high from the first unit until the count is exhausted. With 0 (cycle stealing), `busReq` drops after every unit and rises again only after a new request.
- R3: With mode bit 0 at 0 (external source), a unit is requested only by a rising edge of `dreq` that happens while the channel is waiting. A `dreq` that is already high, or an edge that occurs while the channel owns the bus, is ignored. Negating `dreq` during a unit does not abort it.
- R4: With mode bit 0 at 1 (software source), the channel makes its own requests while mode bit 6 is 1, and keeps waiting while bit 6 is 0. Re-arming with bit 6 still set runs the count again.
- R5: `dreqClr` pulses for one cycle after every unit in cycle-stealing mode, and only after the last unit in burst mode. `tcOut` pulses for one cycle after the last unit, in the same cycle as `dreqClr`.
- R6: Mode bits 2:1 select the unit size: 00 byte, 01 halfword, 10 word, 11 treated as word. `memSize` shows this code. Both addresses advance by 1, 2, 4 or 4 respectively after every unit.
- R7: If `busErr` is high during a read or write cycle, the channel drops `busReq` in the next cycle, returns to idle, sets `errFlag`, and gives no `tcOut`. `errFlag` stays set until the channel is armed again.
- R8: A write to register 3 (`cfgSel`=3) with a non-zero value arms the channel while it is idle or waiting. A zero value does not arm it. Any configuration write made while the channel owns the bus is ignored.
- R9: During and right after reset the channel is idle: `busReq`, `memRd`, `memWr`, `dreqClr`, `tcOut`, `active` and `errFlag` are all low.
- R10: After a request, `busReq` is raised and no read happens until `busGnt` has been sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 mode, 1 source, 2 destination, 3 count |
| cfgWdata | input | DATA_W | Configuration write data |
| dreq | input | 1 | External transfer request |
| dreqClr | output | 1 | Pulse: ready for the next external request |
| tcOut | output | 1 | Pulse: count complete |
| busReq | output | 1 | Bus ownership request |
| busGnt | input | 1 | Bus grant |
| busErr | input | 1 | Bus error for the current cycle |
| memRd | output | 1 | Read cycle strobe |
| memWr | output | 1 | Write cycle strobe |
| memAddr | output | ADDR_W | Bus address |
| memSize | output | 2 | Unit size code |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid in the read cycle |
| active | output | 1 | Channel armed or transferring |
| errFlag | output | 1 | Sticky bus error flag |

## Verification
The assertions assume two things about the bus. A grant, once given, stays high for as long as `busReq` stays high. Read data is valid in the same cycle as `memRd`. The bench meets both: it grants by copying `busReq` at each falling edge, and it returns read data computed combinationally from the address. The assertions also assume that `busErr` is only ever raised during a read or write cycle. The bench raises it only while `memRd` is high, and only on one chosen read.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_REQ  = 3'd2,
    ST_RD   = 3'd3,
    ST_WR   = 3'd4
  } dmaState_e;

  typedef struct packed {
    logic cfgOpen;   // configuration writes accepted
    logic capture;   // latch read data
    logic advance;   // step addresses and count
    logic useDst;    // drive destination address
  } dmaStrobe_t;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_DST  = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

  localparam int MODE_SRC_BIT   = 0;
  localparam int MODE_SIZE_LO   = 1;
  localparam int MODE_BURST_BIT = 5;
  localparam int MODE_SWREQ_BIT = 6;

  function automatic logic [2:0] sizeStep(input logic [1:0] sz);
    case (sz)
      2'b00:   sizeStep = 3'd1;
      2'b01:   sizeStep = 3'd2;
      default: sizeStep = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strb,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              armPulse,
  output logic              burstMode,
  output logic              swMode,
  output logic              swReq,
  output logic              lastUnit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [1:0]        memSize
);

  localparam int PAD_W = ADDR_W - 3;

  logic [ADDR_W-1:0] srcQ, dstQ;
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] dataQ;
  logic [1:0]        sizeQ;
  logic              srcSelQ, burstQ, swReqQ;
  logic [ADDR_W-1:0] stepVal;
  logic              cfgHit;

  assign cfgHit   = cfgWe && strb.cfgOpen;
  assign armPulse = cfgHit && (cfgSel == SEL_CNT) && (cfgWdata[CNT_W-1:0] != '0);
  assign stepVal  = {{PAD_W{1'b0}}, sizeStep(sizeQ)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ    <= '0;
      dstQ    <= '0;
      cntQ    <= '0;
      sizeQ   <= '0;
      srcSelQ <= 1'b0;
      burstQ  <= 1'b0;
      swReqQ  <= 1'b0;
    end else if (cfgHit) begin
      case (cfgSel)
        SEL_MODE: begin
          srcSelQ <= cfgWdata[MODE_SRC_BIT];
          sizeQ   <= cfgWdata[MODE_SIZE_LO +: 2];
          burstQ  <= cfgWdata[MODE_BURST_BIT];
          swReqQ  <= cfgWdata[MODE_SWREQ_BIT];
        end
        SEL_SRC: srcQ <= cfgWdata[ADDR_W-1:0];
        SEL_DST: dstQ <= cfgWdata[ADDR_W-1:0];
        default: cntQ <= cfgWdata[CNT_W-1:0];
      endcase
    end else if (strb.advance) begin
      srcQ <= srcQ + stepVal;
      dstQ <= dstQ + stepVal;
      cntQ <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataQ <= '0;
    else if (strb.capture) dataQ <= memRdata;
  end

  assign burstMode = burstQ;
  assign swMode    = srcSelQ;
  assign swReq     = swReqQ;
  assign lastUnit  = (cntQ == {{(CNT_W-1){1'b0}}, 1'b1});
  assign memAddr   = strb.useDst ? dstQ : srcQ;
  assign memWdata  = dataQ;
  assign memSize   = sizeQ;

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dreq,
  input  logic       busGnt,
  input  logic       busErr,
  input  logic       armPulse,
  input  logic       burstMode,
  input  logic       swMode,
  input  logic       swReq,
  input  logic       lastUnit,
  output dmaStrobe_t strb,
  output logic       busReq,
  output logic       memRd,
  output logic       memWr,
  output logic       dreqClr,
  output logic       tcOut,
  output logic       errFlag,
  output logic       active
);

  dmaState_e stateQ, stateD;
  logic dreqQ, dreqEdge, trigger;
  logic abort, finish, unitDone;

  assign dreqEdge = dreq && !dreqQ;
  assign trigger  = swMode ? swReq : dreqEdge;

  always_comb begin
    stateD   = stateQ;
    abort    = 1'b0;
    finish   = 1'b0;
    unitDone = 1'b0;
    case (stateQ)
      ST_IDLE: if (armPulse) stateD = ST_WAIT;
      ST_WAIT: if (!armPulse && trigger) stateD = ST_REQ;
      ST_REQ:  if (busGnt) stateD = ST_RD;
      ST_RD: begin
        if (busErr) begin
          abort  = 1'b1;
          stateD = ST_IDLE;
        end else begin
          stateD = ST_WR;
        end
      end
      ST_WR: begin
        if (busErr) begin
          abort  = 1'b1;
          stateD = ST_IDLE;
        end else if (lastUnit) begin
          finish = 1'b1;
          stateD = ST_IDLE;
        end else if (burstMode) begin
          stateD = ST_RD;
        end else begin
          unitDone = 1'b1;
          stateD   = ST_WAIT;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      dreqQ   <= 1'b0;
      dreqClr <= 1'b0;
      tcOut   <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      stateQ  <= stateD;
      dreqQ   <= dreq;
      dreqClr <= finish || unitDone;
      tcOut   <= finish;
      if (abort) errFlag <= 1'b1;
      else if (armPulse) errFlag <= 1'b0;
    end
  end

  assign strb.cfgOpen = (stateQ == ST_IDLE) || (stateQ == ST_WAIT);
  assign strb.capture = (stateQ == ST_RD);
  assign strb.advance = (stateQ == ST_WR) && !busErr;
  assign strb.useDst  = (stateQ == ST_WR);

  assign busReq = (stateQ == ST_REQ) || (stateQ == ST_RD) || (stateQ == ST_WR);
  assign memRd  = (stateQ == ST_RD);
  assign memWr  = (stateQ == ST_WR);
  assign active = (stateQ != ST_IDLE);

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic              dreq,
  output logic              dreqClr,
  output logic              tcOut,
  output logic              busReq,
  input  logic              busGnt,
  input  logic              busErr,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              active,
  output logic              errFlag
);

  dmaStrobe_t strb;
  logic armPulse, burstMode, swMode, swReq, lastUnit;

  dma_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dreq     (dreq),
    .busGnt   (busGnt),
    .busErr   (busErr),
    .armPulse (armPulse),
    .burstMode(burstMode),
    .swMode   (swMode),
    .swReq    (swReq),
    .lastUnit (lastUnit),
    .strb     (strb),
    .busReq   (busReq),
    .memRd    (memRd),
    .memWr    (memWr),
    .dreqClr  (dreqClr),
    .tcOut    (tcOut),
    .errFlag  (errFlag),
    .active   (active)
  );

  dma_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgWdata (cfgWdata),
    .memRdata (memRdata),
    .armPulse (armPulse),
    .burstMode(burstMode),
    .swMode   (swMode),
    .swReq    (swReq),
    .lastUnit (lastUnit),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memSize  (memSize)
  );

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busErr,
  input logic              memRd,
  input logic              memWr,
  input logic [ADDR_W-1:0] memAddr,
  input logic [1:0]        memSize,
  input logic              dreqClr,
  input logic              tcOut,
  input logic              errFlag
);

  localparam int PAD_W = ADDR_W - 3;

  // R1: a clean read is followed by the matching write
  p_rd_then_wr_r1: assert property (@(posedge clk) disable iff (!rstN)
    memRd && !busErr |=> memWr && !memRd);

  // R1: read and write never share a cycle
  p_rdwr_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R5: a completion pulse always comes with a clear pulse
  p_tc_with_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    tcOut |-> dreqClr);

  // R5: clear pulses only follow a write cycle
  p_clr_after_wr_r5: assert property (@(posedge clk) disable iff (!rstN)
    dreqClr |-> $past(memWr));

  // R7: a bus error releases the bus and raises the flag
  p_err_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) && busErr |=> !busReq && errFlag && !tcOut);

  // R10: the first cycle of a request never carries a transfer
  p_req_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> !memRd && !memWr);

  // R6: back-to-back burst reads step by the unit size
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    memRd && $past(memRd, 2) |->
      memAddr == $past(memAddr, 2) + {{PAD_W{1'b0}}, sizeStep(memSize)});

endmodule

bind dma_channel dma_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busReq (busReq),
  .busErr (busErr),
  .memRd  (memRd),
  .memWr  (memWr),
  .memAddr(memAddr),
  .memSize(memSize),
  .dreqClr(dreqClr),
  .tcOut  (tcOut),
  .errFlag(errFlag)
);

// File: tb/tb_dma_channel.sv
module tb_dma_channel;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [DATA_W-1:0] cfgWdata = '0;
  logic dreq = 1'b0, busGnt = 1'b0, busErr = 1'b0;
  logic dreqClr, tcOut, busReq, memRd, memWr, active, errFlag;
  logic [ADDR_W-1:0] memAddr;
  logic [1:0] memSize;
  logic [DATA_W-1:0] memWdata, memRdata;

  int total = 0, bad = 0, cycles = 0;
  int wrCount = 0, clrCount = 0, tcCount = 0, reqRise = 0, rdSeen = 0;
  int errOnRead = -1;
  logic prevReq = 1'b0;
  logic [ADDR_W-1:0] firstRdAddr = '0;
  bit grabRd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_channel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .dreq(dreq), .dreqClr(dreqClr), .tcOut(tcOut), .busReq(busReq),
    .busGnt(busGnt), .busErr(busErr), .memRd(memRd), .memWr(memWr),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata),
    .memRdata(memRdata), .active(active), .errFlag(errFlag)
  );

  function automatic logic [31:0] rdFn(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, ~a[15:0]};
  endfunction

  assign memRdata = rdFn(memAddr);

  // Reference model state
  int mState = 0;
  logic [31:0] mSrc = 0, mDst = 0, mData = 0;
  int mCnt = 0;
  logic mSw = 0, mBurst = 0, mSwReq = 0, mErr = 0, mClr = 0, mTc = 0, mDreqQ = 0;
  logic [1:0] mSize = 0;

  function automatic int stepOf(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mSrc = 0; mDst = 0; mData = 0; mCnt = 0;
      mSw = 0; mBurst = 0; mSwReq = 0; mErr = 0; mClr = 0; mTc = 0;
      mDreqQ = 0; mSize = 0;
    end else begin
      automatic logic edgeSeen = dreq && !mDreqQ;
      automatic int oldSt = mState;
      automatic logic arm = cfgWe && cfgSel == 2'd3 && cfgWdata[15:0] != 0 && oldSt <= 1;
      mDreqQ = dreq;
      mClr = 0; mTc = 0;
      case (oldSt)
        0: if (arm) mState = 1;
        1: if (!arm && (mSw ? mSwReq : edgeSeen)) mState = 2;
        2: if (busGnt) mState = 3;
        3: if (busErr) begin mState = 0; mErr = 1; end
           else begin mData = rdFn(mSrc); mState = 4; end
        4: if (busErr) begin mState = 0; mErr = 1; end
           else begin
             mSrc = mSrc + stepOf(mSize); mDst = mDst + stepOf(mSize); mCnt = mCnt - 1;
             if (mCnt == 0) begin mState = 0; mClr = 1; mTc = 1; end
             else if (mBurst) mState = 3;
             else begin mState = 1; mClr = 1; end
           end
        default: mState = 0;
      endcase
      if (cfgWe && oldSt <= 1) begin
        case (cfgSel)
          2'd0: begin mSw = cfgWdata[0]; mSize = cfgWdata[2:1];
                      mBurst = cfgWdata[5]; mSwReq = cfgWdata[6]; end
          2'd1: mSrc = cfgWdata;
          2'd2: mDst = cfgWdata;
          default: mCnt = int'(cfgWdata[15:0]);
        endcase
      end
      if (arm) mErr = 0;
    end
  end

  // Bus responder, event counters and per-cycle comparison
  always @(negedge clk) begin
    busGnt = busReq;
    if (memRd) begin busErr = (rdSeen == errOnRead); rdSeen++; end
    else busErr = 1'b0;
    if (memWr) wrCount++;
    if (dreqClr) clrCount++;
    if (tcOut) tcCount++;
    if (busReq && !prevReq) reqRise++;
    prevReq = busReq;
    if (grabRd && memRd) begin firstRdAddr = memAddr; grabRd = 1'b0; end
    if (rstN) begin
      automatic bit fail = 1'b0;
      automatic logic eReq = (mState >= 2);
      total++;
      if (busReq !== eReq) begin fail = 1;
        $display("FAIL R2/R10 busReq act=%0b exp=%0b", busReq, eReq); end
      if (memRd !== (mState == 3) || memWr !== (mState == 4)) begin fail = 1;
        $display("FAIL R1 rd/wr act=%0b%0b exp=%0b%0b", memRd, memWr, mState == 3, mState == 4); end
      if (mState == 3 && memAddr !== mSrc) begin fail = 1;
        $display("FAIL R6 read addr act=%h exp=%h", memAddr, mSrc); end
      if (mState == 4 && memAddr !== mDst) begin fail = 1;
        $display("FAIL R6 write addr act=%h exp=%h", memAddr, mDst); end
      if (mState == 4 && memWdata !== mData) begin fail = 1;
        $display("FAIL R1 wdata act=%h exp=%h", memWdata, mData); end
      if (memSize !== mSize) begin fail = 1;
        $display("FAIL R6 size act=%0d exp=%0d", memSize, mSize); end
      if (dreqClr !== mClr || tcOut !== mTc) begin fail = 1;
        $display("FAIL R5 clr/tc act=%0b%0b exp=%0b%0b", dreqClr, tcOut, mClr, mTc); end
      if (errFlag !== mErr) begin fail = 1;
        $display("FAIL R7 errFlag act=%0b exp=%0b", errFlag, mErr); end
      if (active !== (mState != 0)) begin fail = 1;
        $display("FAIL R8 active act=%0b exp=%0b", active, mState != 0); end
      if (fail) bad++;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wcfg(input logic [1:0] sel, input logic [31:0] d);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = d;
    step();
    cfgWe = 1'b0;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && active; i++) step();
  endtask

  task automatic waitClr();
    for (int i = 0; i < 60 && !dreqClr; i++) step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0, c0, t0, r0;
    step(3);
    // R9 reset state
    chk(!busReq && !memRd && !memWr && !dreqClr && !tcOut && !active && !errFlag,
        "R9 reset outputs", {busReq, memRd, memWr, active, errFlag}, 0);
    rstN = 1'b1;
    step(2);
    chk(!active && !busReq, "R9 idle after reset", active, 0);

    // R3: level already high ignored; cycle steal, word size
    wcfg(0, 32'h04); wcfg(1, 32'h100); wcfg(2, 32'h200);
    dreq = 1'b1; step();
    w0 = wrCount; c0 = clrCount; t0 = tcCount; r0 = reqRise;
    wcfg(3, 3);
    step(10);
    chk(wrCount == w0, "R3 high level ignored", wrCount - w0, 0);
    dreq = 1'b0; step(2);
    dreq = 1'b1; waitClr(); dreq = 1'b0; step(2);
    dreq = 1'b1; step(); dreq = 1'b0;            // R3 negation mid-unit does not abort
    waitClr(); step(2);
    dreq = 1'b1; waitClr(); dreq = 1'b0; step(2);
    chk(wrCount - w0 == 3, "R3 one unit per edge", wrCount - w0, 3);
    chk(reqRise - r0 == 3, "R2 cycle steal releases bus", reqRise - r0, 3);
    chk(clrCount - c0 == 3, "R5 clear per unit", clrCount - c0, 3);
    chk(tcCount - t0 == 1, "R5 single tc", tcCount - t0, 1);

    // R2 burst, byte size, extra edges ignored
    wcfg(0, 32'h20); wcfg(1, 32'h300); wcfg(2, 32'h400);
    w0 = wrCount; c0 = clrCount; t0 = tcCount; r0 = reqRise;
    wcfg(3, 4);
    dreq = 1'b1; step(3); dreq = 1'b0; step(); dreq = 1'b1; step(); dreq = 1'b0;
    waitIdle(); step(2);
    chk(wrCount - w0 == 4, "R2 burst unit count", wrCount - w0, 4);
    chk(reqRise - r0 == 1, "R2 burst holds bus", reqRise - r0, 1);
    chk(clrCount - c0 == 1, "R5 burst single clear", clrCount - c0, 1);
    chk(tcCount - t0 == 1, "R5 burst tc", tcCount - t0, 1);

    // R4 software, halfword, cycle steal, then repeat
    wcfg(0, 32'h43); wcfg(1, 32'h500); wcfg(2, 32'h600);
    w0 = wrCount; r0 = reqRise;
    wcfg(3, 3); waitIdle(); step(2);
    chk(wrCount - w0 == 3, "R4 software run", wrCount - w0, 3);
    chk(reqRise - r0 == 3, "R2 steal with software requests", reqRise - r0, 3);
    w0 = wrCount; grabRd = 1'b1;
    wcfg(3, 2); waitIdle(); step(2);
    chk(wrCount - w0 == 2, "R4 repeat on rearm", wrCount - w0, 2);
    chk(firstRdAddr == 32'h506, "R6 halfword continues", int'(firstRdAddr), 32'h506);

    // R4 request bit clear waits; size 11 behaves as word
    wcfg(0, 32'h07); wcfg(1, 32'h700); wcfg(2, 32'h800);
    w0 = wrCount;
    wcfg(3, 2); step(15);
    chk(wrCount == w0 && active, "R4 waits without request bit", wrCount - w0, 0);
    wcfg(0, 32'h47); waitIdle(); step(2);
    chk(wrCount - w0 == 2, "R4 starts when bit set", wrCount - w0, 2);

    // R8 zero count does not arm
    wcfg(3, 0); step(5);
    chk(!active, "R8 zero count no arm", active, 0);

    // R7 error on second read of a software burst
    wcfg(0, 32'h65); wcfg(1, 32'h900); wcfg(2, 32'hA00);
    w0 = wrCount; t0 = tcCount;
    errOnRead = rdSeen + 1;
    wcfg(3, 5); waitIdle(); step(2);
    chk(errFlag, "R7 sticky error", errFlag, 1);
    chk(wrCount - w0 == 1, "R7 abort stops units", wrCount - w0, 1);
    chk(tcCount == t0, "R7 no tc on abort", tcCount - t0, 0);
    step(5);
    chk(errFlag && !busReq, "R7 flag holds, bus released", errFlag, 1);

    // R8 writes during ownership ignored; rearm clears error
    errOnRead = -1;
    wcfg(1, 32'hB00); wcfg(2, 32'hC00);
    wcfg(3, 2);
    chk(!errFlag, "R7 rearm clears flag", errFlag, 0);
    for (int i = 0; i < 20 && !memRd; i++) step();
    wcfg(1, 32'hDEAD0);
    waitIdle(); step(2);
    grabRd = 1'b1;
    wcfg(3, 1); waitIdle(); step(2);
    chk(firstRdAddr == 32'hB08, "R8 busy write ignored", int'(firstRdAddr), 32'hB08);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule